// File: doc/BRIEF.md
# Interrupt Status and Enable Register Pair

This block collects five single-cycle event pulses from the link controller's datapath into a byte-wide sticky status register. The events are transmit done, receive done, transmit underrun, receive overflow and serial gap received. A companion enable register selects which of the latched events raise the level interrupt line. Software reaches both registers over a plain byte-wide register bus with a write strobe. Reads are combinational on the address.

Transmit done is latched only when the datapath marks the finished transmit descriptor as one that asked for an interrupt. Any other transmit completion leaves the status untouched. Software acknowledges an event by writing a one to its status bit. When a new event arrives in the same cycle as its acknowledge, the new event is kept. The three low bits of both registers are not backed by storage and always read as one.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset every status bit and every enable bit is 0. Reading the status address (0x0C) gives 0x07, reading the enable address (0x0D) gives 0x07, and `irq` is low.
- R2: A pulse on an event input sets its status bit on the next clock edge, and the bit stays set until software clears it. The bit positions are: transmit done = bit 7, receive done = bit 6, transmit underrun = bit 5, receive overflow = bit 4, serial gap = bit 3.
- R3: A pulse on `ev_tx_done` sets bit 7 only when `ev_tx_irq_req` is high in the same cycle. With `ev_tx_irq_req` low, bit 7 is unchanged.
- R4: A write to the status address clears every status bit in 7..3 whose written bit is 1. Status bits whose written bit is 0 are unchanged.
- R5: A write to the enable address loads bits 7..3 of the written byte into the enable register. A 1 enables that source and a 0 disables it.
- R6: Bits 2..0 of both registers always read as 1, and writes to those bits have no effect.
- R7: `irq` is high exactly when some bit position is set in both the status register and the enable register.
- R8: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Writes to any address other than 0x0C and 0x0D change no register, and reads of such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ev_tx_done | input | 1 | Transmit descriptor finished |
| ev_tx_irq_req | input | 1 | The finished descriptor requested an interrupt |
| ev_rx_done | input | 1 | Receive completed |
| ev_tx_under | input | 1 | Transmit FIFO underrun |
| ev_rx_over | input | 1 | Receive FIFO overflow |
| ev_gap | input | 1 | Serial gap received |
| irq | output | 1 | Level interrupt request |

## Verification
The bench steps through all 32 event patterns, all 32 clear masks and every enable-by-status pairing, and predicts each read value and the `irq` level arithmetically.

It targets several specific mistakes:
- A design that gates transmit done wrongly would either set bit 7 without the descriptor flag or drop it when the flag is present.
- A design that lets the clear win a same-cycle collision would lose an event, and the collision test shows this as a missing status bit.
- A design that stores the low bits, or decodes addresses loosely, would read back zeros in bits 2..0 or would let a write to a stray address alter the enable register.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
    localparam int unsigned REG_W     = 8;
    localparam int unsigned NUM_SRC   = 5;
    localparam int unsigned LOW_W     = REG_W - NUM_SRC;
    localparam int unsigned ADDR_W    = 5;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 5'h0C;
    localparam logic [ADDR_W-1:0] EN_ADDR   = 5'h0D;
    // index of each source inside the NUM_SRC-wide vector (bit 7..3 of the byte)
    localparam int unsigned SRC_TXDONE = 4;
    localparam int unsigned SRC_RXDONE = 3;
    localparam int unsigned SRC_TXUNDR = 2;
    localparam int unsigned SRC_RXOVER = 1;
    localparam int unsigned SRC_GAP    = 0;
endpackage

// File: rtl/irq_sticky_status.sv
module irq_sticky_status #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        status_o[i] <= 1'b0;
            else if (set_i[i]) status_o[i] <= 1'b1;   // event wins over clear
            else if (clr_i[i]) status_o[i] <= 1'b0;
        end
    end

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(set_i)) == $past(set_i)));          // R2, R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i))); // R2
    AST_CLEAR_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~status_o & $past(status_o)) == (~status_o & $past(status_o) & $past(clr_i & ~set_i)))); // R4
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] data_i,
    output logic [N-1:0] enable_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      enable_o <= '0;
        else if (load_i) enable_o <= data_i;
    end

    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(enable_o));                                  // R5
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_regs_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] enable_i,
    output logic [REG_W-1:0]   rdata_o
);
    always_comb begin
        unique case (addr_i)
            STAT_ADDR: rdata_o = {status_i, {LOW_W{1'b1}}};
            EN_ADDR:   rdata_o = {enable_i, {LOW_W{1'b1}}};
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ev_tx_done,
    input  logic              ev_tx_irq_req,
    input  logic              ev_rx_done,
    input  logic              ev_tx_under,
    input  logic              ev_rx_over,
    input  logic              ev_gap,
    output logic              irq
);
    logic [NUM_SRC-1:0] ev_vec, clr_vec, status, enable;
    logic               wr_stat, wr_en;

    always_comb begin
        ev_vec             = '0;
        ev_vec[SRC_TXDONE] = ev_tx_done & ev_tx_irq_req;
        ev_vec[SRC_RXDONE] = ev_rx_done;
        ev_vec[SRC_TXUNDR] = ev_tx_under;
        ev_vec[SRC_RXOVER] = ev_rx_over;
        ev_vec[SRC_GAP]    = ev_gap;
    end

    assign wr_stat = reg_wr && (reg_addr == STAT_ADDR);
    assign wr_en   = reg_wr && (reg_addr == EN_ADDR);
    assign clr_vec = wr_stat ? reg_wdata[REG_W-1 -: NUM_SRC] : '0;

    irq_sticky_status #(.N(NUM_SRC)) u_status (
        .clk(clk), .rst_n(rst_n), .set_i(ev_vec), .clr_i(clr_vec), .status_o(status));

    irq_enable_reg #(.N(NUM_SRC)) u_enable (
        .clk(clk), .rst_n(rst_n), .load_i(wr_en),
        .data_i(reg_wdata[REG_W-1 -: NUM_SRC]), .enable_o(enable));

    irq_read_mux u_rmux (
        .addr_i(reg_addr), .status_i(status), .enable_i(enable), .rdata_o(reg_rdata));

    assign irq = |(status & enable);

    AST_TXDONE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[SRC_TXDONE]) |-> $past(ev_tx_done && ev_tx_irq_req)); // R3
    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && reg_wdata[REG_W-1 -: NUM_SRC] == '0) |-> !irq);    // R7
    AST_LOW_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == STAT_ADDR || reg_addr == EN_ADDR) |-> (reg_rdata[LOW_W-1:0] == '1)); // R6
    AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != STAT_ADDR && reg_addr != EN_ADDR) |-> (reg_rdata == '0)); // R9
endmodule

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;
    logic       clk = 0, rst_n = 0;
    logic [4:0] reg_addr = 0;
    logic       reg_wr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       ev_tx_done = 0, ev_tx_irq_req = 0, ev_rx_done = 0;
    logic       ev_tx_under = 0, ev_rx_over = 0, ev_gap = 0, irq;
    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    irq_status_ctrl u_irq_status_ctrl (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    // drive write and/or event pattern p (bit4=txdone .. bit0=gap) for one cycle
    task automatic cyc(input logic wr, input logic [4:0] a, input logic [7:0] wd,
                       input logic [4:0] p, input logic txreq);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        {ev_tx_done, ev_rx_done, ev_tx_under, ev_rx_over, ev_gap} = p;
        ev_tx_irq_req = txreq;
        @(negedge clk);
        reg_wr = 0;
        {ev_tx_done, ev_rx_done, ev_tx_under, ev_rx_over, ev_gap} = 0;
        ev_tx_irq_req = 0;
    endtask

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (2) @(negedge clk);
        rd(5'h0C, d); chk("R1 status reset", d, 8'h07);
        rd(5'h0D, d); chk("R1 enable reset", d, 8'h07);
        chk("R1 irq reset", {7'd0, irq}, 8'h00);
        rst_n = 1;

        // R2: each pattern latches and is sticky
        for (int p = 0; p < 32; p++) begin
            cyc(1, 5'h0C, 8'hFF, 0, 0);
            cyc(0, 0, 0, p[4:0], 1);
            rd(5'h0C, d); chk("R2 latch", d, {p[4:0], 3'b111});
            cyc(0, 0, 0, 0, 0);
            rd(5'h0C, d); chk("R2 sticky", d, {p[4:0], 3'b111});
        end

        // R3: tx done without descriptor request
        for (int p = 0; p < 32; p++) begin
            cyc(1, 5'h0C, 8'hFF, 0, 0);
            cyc(0, 0, 0, p[4:0], 0);
            rd(5'h0C, d); chk("R3 txdone gated", d, {1'b0, p[3:0], 3'b111});
        end

        // R4/R6: write-one-to-clear masks, low bits varied
        for (int m = 0; m < 32; m++) begin
            cyc(0, 0, 0, 5'h1F, 1);
            cyc(1, 5'h0C, {m[4:0], m[2:0]}, 0, 0);
            rd(5'h0C, d); chk("R4 w1c", d, {~m[4:0], 3'b111});
        end

        // R5/R6/R7: enable x status sweep
        for (int e = 0; e < 32; e++) begin
            cyc(1, 5'h0D, {e[4:0], 3'b000}, 0, 0);
            rd(5'h0D, d); chk("R5 enable readback", d, {e[4:0], 3'b111});
            for (int s = 0; s < 32; s++) begin
                cyc(1, 5'h0C, 8'hFF, 0, 0);
                cyc(0, 0, 0, s[4:0], 1);
                chk("R7 irq level", {7'd0, irq}, {7'd0, |(e[4:0] & s[4:0])});
            end
        end

        // R8: event and clear collide
        cyc(1, 5'h0C, 8'hFF, 0, 0);
        cyc(1, 5'h0C, 8'hF8, 5'h1F, 1);
        rd(5'h0C, d); chk("R8 all collide", d, 8'hFF);
        cyc(1, 5'h0C, 8'hF8, 5'b01000, 0);
        rd(5'h0C, d); chk("R8 one survives", d, 8'h47);

        // R9: stray addresses
        cyc(1, 5'h0D, 8'hA8, 0, 0);
        cyc(0, 0, 0, 5'h1F, 1);
        for (int a = 0; a < 32; a++) begin
            if (a == 12 || a == 13) continue;
            cyc(1, a[4:0], 8'hFF, 0, 0);
            rd(a[4:0], d); chk("R9 stray read", d, 8'h00);
        end
        rd(5'h0D, d); chk("R9 enable untouched", d, 8'hAF);
        rd(5'h0C, d); chk("R9 status untouched", d, 8'hFF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule